// File: doc/BRIEF.md
# Programmable Ratio Clock Divider

This block takes a fast source clock and produces a slower clock whose period is a whole number of source cycles. The number is picked by a 4-bit divide code and a table-select bit. The two low code bits choose a small base ratio, and the two high code bits scale that base by a power of two. The output is built from half-cycle slots, so it has an exact 50% duty cycle for odd ratios as well as even ones. It can also be inverted, gated off by an enable input, or parked by an active-low power-down request.

All settings are sampled only on the source edge that ends the current output period. A setting change therefore never shortens or stretches a pulse, and stopping or restarting the clock never produces a runt. After reset, the divider runs one full period with the reset-default code before it reads the live inputs.

Top module: `clkdiv_top`

## Requirements
- R1: With table select 0 and code bits [3:2] = 00, code bits [1:0] of 00, 01, 10 and 11 give output periods of 2, 3, 5 and 7 source cycles.
- R2: With table select 1 and code bits [3:2] = 00, code bits [1:0] of 00, 01, 10 and 11 give periods of 4, 3, 5 and 9 source cycles.
- R3: Code bits [3:2] of 00, 01, 10 and 11 multiply the base period by 1, 2, 4 and 8, up to 56 cycles in table 0 and 72 cycles in table 1.
- R4: For a period of N source cycles, the non-inverted output is high for the first N half-cycles of the period and low for the last N half-cycles. This holds for odd N too.
- R5: With the invert input at 1, the output is low for the first N half-cycles of the period and high for the last N half-cycles.
- R6: An enable input of 0, sampled at the end of a period, holds the output at 0 for the whole next period. An enable of 1 lets the next period run in full. The output never shows a partial pulse.
- R7: The power-down input parks the output like enable 0 does, but only when it is sampled low on the period-ending edge and on the edge just before it. A power-down input that is low for a single edge has no effect.
- R8: The code, table select, invert, enable and power-down inputs are sampled only on the last-cycle edge of a period. They act from the next source cycle onward. Changes made in the middle of a period have no effect.
- R9: The output is 0 while reset is low. The first period after reset runs with the default code (0101 in table 0, a period of 6 cycles), not inverted and enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 4 | Divide code: [1:0] select the base ratio, [3:2] select the power-of-two scale |
| tbl_sel | input | 1 | Ratio table select (0 or 1) |
| invert | input | 1 | Phase inversion of the divided clock when 1 |
| enable | input | 1 | 1 runs the output, 0 parks it low |
| pd_n | input | 1 | Active-low power-down request, qualified over two edges |
| clk_div | output | 1 | Divided clock |

## Verification
A period-ending edge can carry a new ratio, a new phase and a stop or restart all at once. The bench forces this by changing the code, table, invert, enable and power-down inputs in the same cycle, at points that fall both on and between period boundaries. A behavioural reference model tracks the period position and the qualified power-down history. It predicts the value of the output in both halves of every source cycle. Any slot where the design is early, late, truncated or left running after a stop counts as a mismatch.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int CODE_W      = 4;
   localparam int BASE_W      = 4;
   localparam int SCALE_SHIFT = 3;
   localparam int RATIO_W     = BASE_W + SCALE_SHIFT;

   // bit 0: first half of a source cycle, bit 1: second half
   typedef logic [1:0] slot_pair_t;

   typedef struct packed {
      logic [RATIO_W-1:0] ratio;
      logic               inv;
   } div_cfg_t;

   // R1 R2 R3: base from code[1:0] and table, scaled by 2**code[3:2]
   function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] code,
                                                   input logic              tbl);
      logic [BASE_W-1:0] base;
      case ({tbl, code[1:0]})
         3'b000:  base = 4'd2;
         3'b001:  base = 4'd3;
         3'b010:  base = 4'd5;
         3'b011:  base = 4'd7;
         3'b100:  base = 4'd4;
         3'b101:  base = 4'd3;
         3'b110:  base = 4'd5;
         default: base = 4'd9;
      endcase
      return RATIO_W'(base) << code[3:2];
   endfunction

endpackage

// File: rtl/clkdiv_pd_filter.sv
module clkdiv_pd_filter #(
   parameter int SAMPLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_n,
   output logic pd_hold
);

   if (SAMPLES == 1) begin : g_direct
      assign pd_hold = ~pd_n;
   end else begin : g_hist
      localparam int HD = SAMPLES - 1;
      logic [HD-1:0] hist_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= '1;
         else        hist_q <= HD'({hist_q, pd_n});
      end

      // R7: low now and on each of the previous SAMPLES-1 edges
      assign pd_hold = ~pd_n & ~(|hist_q);
   end

endmodule

// File: rtl/clkdiv_period_ctrl.sv
module clkdiv_period_ctrl
   import clkdiv_pkg::*;
#(
   parameter logic [CODE_W-1:0] RST_CODE  = 4'b0101,
   parameter logic              RST_TABLE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CODE_W-1:0]  code_in,
   input  logic               tbl_in,
   input  logic               inv_in,
   input  logic               en_in,
   input  logic               pd_hold,
   output slot_pair_t         pair_d,
   output logic [RATIO_W-1:0] cnt_q,
   output logic               run_q,
   output div_cfg_t           cfg_q
);

   localparam logic [RATIO_W-1:0] RST_RATIO = ratio_of(RST_CODE, RST_TABLE);

   logic               at_end;
   logic [RATIO_W-1:0] cnt_d;
   div_cfg_t           cfg_d;
   logic               run_d;
   logic               h0, h1;

   always_comb begin
      at_end = (cnt_q == cfg_q.ratio - RATIO_W'(1));
      cfg_d  = cfg_q;
      run_d  = run_q;
      cnt_d  = cnt_q + RATIO_W'(1);
      if (at_end) begin
         // R8: every setting is taken only here
         cfg_d.ratio = ratio_of(code_in, tbl_in);
         cfg_d.inv   = inv_in;
         run_d       = en_in & ~pd_hold;          // R6 R7
         cnt_d       = '0;
      end
      // R4: half-slot 2c and 2c+1 are high while below the ratio
      h0     = {cnt_d, 1'b0} < {1'b0, cfg_d.ratio};
      h1     = {cnt_d, 1'b1} < {1'b0, cfg_d.ratio};
      pair_d = {run_d & (cfg_d.inv ^ h1), run_d & (cfg_d.inv ^ h0)};   // R5
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         run_q     <= 1'b1;                 // R9
         cfg_q.ratio <= RST_RATIO;
         cfg_q.inv <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         run_q <= run_d;
         cfg_q <= cfg_d;
      end
   end

endmodule

// File: rtl/clkdiv_wave_out.sv
module clkdiv_wave_out
   import clkdiv_pkg::*;
#(
   parameter slot_pair_t RST_PAIR = 2'b11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  slot_pair_t pair_d,
   output logic       clk_div
);

   slot_pair_t nxt_q;
   logic       p_q;
   logic       n_pre_q;
   logic       n_q;

   // p_q covers a slot pair only when both halves are high; n_q covers the
   // second half of a cycle together with the first half of the next one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt_q   <= RST_PAIR;
         p_q     <= 1'b0;
         n_pre_q <= 1'b0;
      end else begin
         nxt_q   <= pair_d;
         p_q     <= nxt_q[0] & nxt_q[1];
         n_pre_q <= nxt_q[1] & pair_d[0];
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) n_q <= 1'b0;
      else        n_q <= n_pre_q;
   end

   assign clk_div = p_q | n_q;

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
   import clkdiv_pkg::*;
#(
   parameter logic [CODE_W-1:0] RST_CODE   = 4'b0101,
   parameter logic              RST_TABLE  = 1'b0,
   parameter int                PD_SAMPLES = 2
) (
   input  logic              clk_src,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] div_code,
   input  logic              tbl_sel,
   input  logic              invert,
   input  logic              enable,
   input  logic              pd_n,
   output logic              clk_div
);

   if (PD_SAMPLES < 1) begin : g_bad_pd
      $error("PD_SAMPLES must be at least 1");
   end
   if (CODE_W != 4) begin : g_bad_code
      $error("divide code must be 4 bits wide");
   end
   if (ratio_of(RST_CODE, RST_TABLE) < 2) begin : g_bad_rst
      $error("reset ratio must be at least 2");
   end

   logic               pd_hold;
   slot_pair_t         pair_d;
   logic [RATIO_W-1:0] cnt_q;
   logic               run_q;
   div_cfg_t           cfg_q;

   clkdiv_pd_filter #(.SAMPLES(PD_SAMPLES)) u_pd (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .pd_n    (pd_n),
      .pd_hold (pd_hold)
   );

   clkdiv_period_ctrl #(.RST_CODE(RST_CODE), .RST_TABLE(RST_TABLE)) u_ctrl (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .code_in (div_code),
      .tbl_in  (tbl_sel),
      .inv_in  (invert),
      .en_in   (enable),
      .pd_hold (pd_hold),
      .pair_d  (pair_d),
      .cnt_q   (cnt_q),
      .run_q   (run_q),
      .cfg_q   (cfg_q)
   );

   // reset period is running and non-inverted, ratio >= 2: first two slots high
   clkdiv_wave_out #(.RST_PAIR(2'b11)) u_wave (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .pair_d  (pair_d),
      .clk_div (clk_div)
   );

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
   import clkdiv_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               pd_n,
   input logic               enable,
   input logic               clk_div,
   input logic [RATIO_W-1:0] cnt_q,
   input logic               run_q,
   input div_cfg_t           cfg_q
);

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !clk_div);   // R9

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < cfg_q.ratio);   // R3

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> ($stable(cfg_q) && $stable(run_q)));   // R8

   AST_EN_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0 && cnt_q == '0 && !$past(enable)) |-> !run_q);   // R6

   AST_PD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && cnt_q == '0 && !$past(pd_n) && !$past(pd_n, 2)) |-> !run_q);   // R7

   AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && !run_q && !$past(run_q)) |-> !clk_div);   // R6

endmodule

bind clkdiv_top clkdiv_checker u_chk (
   .clk     (clk_src),
   .rst_n   (rst_n),
   .pd_n    (pd_n),
   .enable  (enable),
   .clk_div (clk_div),
   .cnt_q   (cnt_q),
   .run_q   (run_q),
   .cfg_q   (cfg_q)
);

// File: tb/clkdiv_top_tb_top.sv
`timescale 1ns/1ps
module clkdiv_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] code = 4'b0000;
   logic       tbl = 1'b0;
   logic       inv = 1'b0;
   logic       en = 1'b1;
   logic       pd_n = 1'b1;
   logic       clk_div;

   always #4 clk = ~clk;

   clkdiv_top dut_i (
      .clk_src  (clk),
      .rst_n    (rst_n),
      .div_code (code),
      .tbl_sel  (tbl),
      .invert   (inv),
      .enable   (en),
      .pd_n     (pd_n),
      .clk_div  (clk_div)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   string tag      = "R9";

   logic [1:0] exp_q[$];
   int m_pos, m_ratio, m_pdlow;
   bit m_inv, m_run;

   function automatic int ratio_ref(logic [3:0] c, logic t);
      int b;
      if (t) b = (c[1:0] == 2'd0) ? 4 : (c[1:0] == 2'd1) ? 3 : (c[1:0] == 2'd2) ? 5 : 9;
      else   b = (c[1:0] == 2'd0) ? 2 : (c[1:0] == 2'd1) ? 3 : (c[1:0] == 2'd2) ? 5 : 7;
      return b * (1 << c[3:2]);
   endfunction

   function automatic logic [1:0] pair_ref(int pos, int n, bit iv, bit rn);
      logic a, b;
      a = rn && (((2 * pos) < n) != iv);
      b = rn && (((2 * pos + 1) < n) != iv);
      return {b, a};
   endfunction

   task automatic check(logic got, logic want, string half);
      n_checks++;
      if (got !== want) begin
         n_fail++;
         $display("FAIL %s %s half at %0t: got %b expected %b", tag, half, $time, got, want);
      end
   endtask

   task automatic cycle_step();
      logic [1:0] e;
      @(posedge clk);
      e = exp_q.pop_front();
      if (!pd_n) m_pdlow++; else m_pdlow = 0;
      if (m_pos == m_ratio - 1) begin
         m_ratio = ratio_ref(code, tbl);
         m_inv   = inv;
         m_run   = en && (m_pdlow < 2);
         m_pos   = 0;
      end else begin
         m_pos++;
      end
      exp_q.push_back(pair_ref(m_pos, m_ratio, m_inv, m_run));
      #2 check(clk_div, e[0], "first");
      #4 check(clk_div, e[1], "second");
   endtask

   task automatic run(int n);
      repeat (n) cycle_step();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired, expected the run to end");
      summary();
      $finish;
   end

   initial begin
      // R9: quiet during reset
      repeat (3) begin
         @(posedge clk);
         #2 check(clk_div, 1'b0, "reset");
      end
      #4;
      rst_n = 1'b1;
      exp_q.push_back(2'b11);
      m_pos = 0; m_ratio = 6; m_inv = 0; m_run = 1; m_pdlow = 0;
      tag = "R9";
      run(12);

      // R1 R2 R3 R4: every code in both tables
      for (int t = 0; t < 2; t++) begin
         for (int c = 0; c < 16; c++) begin
            code = 4'(c);
            tbl  = t[0];
            if (t == 1)          tag = "R2/R4";
            else if (c < 4)      tag = "R1/R4";
            else                 tag = "R3/R4";
            run(3 * ratio_ref(code, tbl) + 1);
         end
      end

      // R5: inverted phase on odd and even ratios
      tag = "R5";
      inv = 1'b1;
      code = 4'b0001; tbl = 1'b0; run(12);
      code = 4'b0011; run(24);
      code = 4'b0110; tbl = 1'b1; run(64);
      code = 4'b1011; run(220);
      inv = 1'b0;

      // R8: mid-period changes are ignored until the period ends
      tag = "R8";
      code = 4'b1111; tbl = 1'b1; run(80);
      for (int i = 0; i < 12; i++) begin
         code = 4'((i * 5) % 16);
         inv  = i[0];
         tbl  = i[1];
         run(5);
      end
      code = 4'b0100; tbl = 1'b0; inv = 1'b0; run(60);

      // R6: enable parks and restarts on period boundaries
      tag = "R6";
      code = 4'b0001;
      en = 1'b0; run(40);
      en = 1'b1; run(1);
      en = 1'b0; run(1);
      en = 1'b1; run(30);
      inv = 1'b1; en = 1'b0; run(20);
      en = 1'b1; run(20);
      inv = 1'b0;

      // R7: single-edge power-down ignored, two-edge low parks
      tag = "R7";
      code = 4'b0010;
      for (int i = 0; i < 6; i++) begin
         pd_n = 1'b0; run(1);
         pd_n = 1'b1; run(2);
      end
      pd_n = 1'b0; run(2);
      pd_n = 1'b1; run(20);
      pd_n = 1'b0; run(40);
      pd_n = 1'b1; run(30);

      // R6/R8: stop and setting change in the same cycle
      tag = "R6/R8";
      code = 4'b1101; en = 1'b0; inv = 1'b1; run(50);
      code = 4'b0011; tbl = 1'b1; en = 1'b1; run(60);
      tag = "R7/R8";
      code = 4'b0000; pd_n = 1'b0; inv = 1'b0; run(30);
      code = 4'b0101; tbl = 1'b0; pd_n = 1'b1; run(30);

      summary();
      $finish;
   end

endmodule